// File: doc/BRIEF.md
# Two-Level Segment and Page Address Translator

This block turns a 24-bit virtual address into a 24-bit physical address. The top four bits pick a segment, the next eight bits pick a page inside that segment, and the low twelve bits are the byte offset. The segment table sits in memory at the address given on `seg_table_base`. Only segment numbers below `seg_limit` are valid. Each segment entry names a page table in memory and gives the segment's page count and its access rights. The block reads the chosen page table entry and joins its frame number with the offset.

The caller hands over one request at a time on a valid/ready port. The request is held until `req_ready` is high, and `req_ready` is high only while the block is idle. All table reads go out one at a time on a 16-bit read port with a valid/ready request side. Each read waits for one `mem_rsp_valid` pulse before the next read is issued. The response side takes no back-pressure. The result is held on the response port until the consumer takes it. While `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady.

Top module: `ptx_translator`

## Requirements
- R1: A successful translation returns `rsp_fault` = 00 and `rsp_paddr` = {page table entry bits [11:0], virtual address bits [11:0]}. Bits [15:12] of the page table entry are ignored.
- R2: A segment entry is three 16-bit words at byte addresses `seg_table_base` + 8·segment + 0, +2 and +4, read in that order:
  - word 0 is page table base [15:0];
  - word 1 holds page table base [23:16] in bits [7:0] and the page count in bits [15:8];
  - word 2 holds the access code in bits [1:0].
- R3: The page table entry is read from page table base + 2·page number. It is the fourth and last read of a successful translation.
- R4: A page number greater than or equal to the page count gives fault 01. No page table read is issued for it.
- R5: Access codes are 01 read-only, 10 read-write, and 00 or 11 no access. A write to a read-only segment, or any access to a no-access segment, gives fault 10 with no page table read. Fault 10 takes precedence over fault 01.
- R6: A segment number greater than or equal to `seg_limit` gives fault 11 and issues no memory read. With the accepting clock edge counted as edge 0, `rsp_valid` is high right after edge 0.
- R7: With `mem_req_ready` held high and read data returned in the cycle after each accepted read, `rsp_valid` rises at edge 9 after acceptance for a successful translation. It rises at edge 7 for fault 01 or fault 10.
- R8: `req_ready` is low from the accepting edge until the response has been taken, so only one request is in flight.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold their values.
- R11: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R12: Every faulting response carries `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_table_base | input | 24 | Byte address of segment table entry 0 |
| seg_limit | input | 5 | Number of valid segments (0 to 16) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | 24 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 24 | Byte address of the 16-bit word to read |
| mem_rsp_valid | input | 1 | Read data present (one pulse per read) |
| mem_rsp_data | input | 16 | Read data |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 24 | Physical address, zero on a fault |
| rsp_fault | output | 2 | 00 ok, 01 bounds, 10 protection, 11 invalid segment |

## Verification
With a zero-wait memory, a result is due at a fixed edge after the accepting edge:
- an invalid segment is answered right after that edge;
- a bounds or protection fault is answered after edge 7;
- a full translation is answered after edge 9.

The bench counts falling edges from the accepting edge until `rsp_valid` first rises and compares the count with the expected latency. It compares the captured result with a behavioural model computed from the memory contents, and compares the list of read addresses seen on the memory port with the model's list. For a transaction with a stalling memory and a held `rsp_ready`, the bench drops the latency check. It then checks the stability rules on every falling edge instead.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_BOUND = 2'b01,
    FLT_PROT  = 2'b10,
    FLT_SEG   = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_RW   = 2'b10,
    ACC_RSVD = 2'b11
  } access_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_CHECK,
    ST_RESP
  } state_e;

  // byte stride of one segment entry is 1 << ENTRY_SHIFT
  localparam int ENTRY_SHIFT = 3;
  localparam int LAST_WORD   = 2;
endpackage

// File: rtl/ptx_seg_entry.sv
module ptx_seg_entry
  import ptx_pkg::*;
#(
  parameter int PA_W   = 24,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        word_idx,
  input  logic [DATA_W-1:0] word,
  output logic [PA_W-1:0]   pt_base,
  output logic [PAGE_W-1:0] pg_count,
  output access_e           access
);
  localparam int HI_W = PA_W - DATA_W;

  logic [DATA_W-1:0] lo_q, hi_q;
  logic [1:0]        acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      acc_q <= '0;
    end else if (load) begin
      case (word_idx)
        2'd0:    lo_q  <= word;
        2'd1:    hi_q  <= word;
        default: acc_q <= word[1:0];
      endcase
    end
  end

  assign pt_base  = {hi_q[HI_W-1:0], lo_q};
  assign pg_count = hi_q[HI_W +: PAGE_W];
  assign access   = access_e'(acc_q);
endmodule

// File: rtl/ptx_access_check.sv
module ptx_access_check
  import ptx_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  access_e           access,
  input  logic              is_write,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] pg_count,
  output fault_e            fault
);
  always_comb begin
    fault = FLT_NONE;
    case (access)
      ACC_RO:  if (is_write) fault = FLT_PROT;
      ACC_RW:  fault = FLT_NONE;
      default: fault = FLT_PROT;
    endcase
    // protection wins over bounds
    if (fault == FLT_NONE && page >= pg_count) fault = FLT_BOUND;
  end
endmodule

// File: rtl/ptx_addr_gen.sv
module ptx_addr_gen
  import ptx_pkg::*;
#(
  parameter int PA_W   = 24,
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8
) (
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [SEG_W-1:0]  seg,
  input  logic [1:0]        word_idx,
  input  logic              pt_phase,
  input  logic [PA_W-1:0]   pt_base,
  input  logic [PAGE_W-1:0] page,
  output logic [PA_W-1:0]   addr
);
  logic [PA_W-1:0] seg_addr, pte_addr;

  always_comb begin
    seg_addr = tbl_base + (PA_W'(seg) << ENTRY_SHIFT) + (PA_W'(word_idx) << 1);
    pte_addr = pt_base + (PA_W'(page) << 1);
    addr     = pt_phase ? pte_addr : seg_addr;
  end
endmodule

// File: rtl/ptx_translator.sv
module ptx_translator
  import ptx_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 12,
  parameter int DATA_W  = 16,
  localparam int VA_W   = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   seg_table_base,
  input  logic [SEG_W:0]    seg_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault
);
  state_e            state_q;
  logic [VA_W-1:0]   vaddr_q;
  logic              write_q;
  logic [1:0]        idx_q;
  logic              pt_q;
  fault_e            fault_q;
  logic [PA_W-1:0]   paddr_q;

  logic [SEG_W-1:0]  seg_f;
  logic [PAGE_W-1:0] page_f;
  logic [OFF_W-1:0]  off_f;
  logic [SEG_W-1:0]  req_seg;
  logic              req_seg_bad;

  logic [PA_W-1:0]   pt_base;
  logic [PAGE_W-1:0] pg_count;
  access_e           access;
  fault_e            chk_fault;
  logic              entry_load;

  assign seg_f       = vaddr_q[VA_W-1 -: SEG_W];
  assign page_f      = vaddr_q[OFF_W +: PAGE_W];
  assign off_f       = vaddr_q[OFF_W-1:0];
  assign req_seg     = req_vaddr[VA_W-1 -: SEG_W];
  assign req_seg_bad = {1'b0, req_seg} >= seg_limit;
  assign entry_load  = (state_q == ST_WAIT) && mem_rsp_valid && !pt_q;

  ptx_seg_entry #(.PA_W(PA_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (entry_load),
    .word_idx (idx_q),
    .word     (mem_rsp_data),
    .pt_base  (pt_base),
    .pg_count (pg_count),
    .access   (access)
  );

  ptx_access_check #(.PAGE_W(PAGE_W)) u_check (
    .access   (access),
    .is_write (write_q),
    .page     (page_f),
    .pg_count (pg_count),
    .fault    (chk_fault)
  );

  ptx_addr_gen #(.PA_W(PA_W), .SEG_W(SEG_W), .PAGE_W(PAGE_W)) u_addr (
    .tbl_base (seg_table_base),
    .seg      (seg_f),
    .word_idx (idx_q),
    .pt_phase (pt_q),
    .pt_base  (pt_base),
    .page     (page_f),
    .addr     (mem_req_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      write_q <= 1'b0;
      idx_q   <= '0;
      pt_q    <= 1'b0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          write_q <= req_write;
          idx_q   <= '0;
          pt_q    <= 1'b0;
          if (req_seg_bad) begin
            fault_q <= FLT_SEG;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (pt_q) begin
            paddr_q <= {mem_rsp_data[FRAME_W-1:0], off_f};
            fault_q <= FLT_NONE;
            state_q <= ST_RESP;
          end else if (idx_q == 2'(LAST_WORD)) begin
            state_q <= ST_CHECK;
          end else begin
            idx_q   <= idx_q + 2'd1;
            state_q <= ST_ISSUE;
          end
        end
        ST_CHECK: begin
          if (chk_fault != FLT_NONE) begin
            fault_q <= chk_fault;
            paddr_q <= '0;
            state_q <= ST_RESP;
          end else begin
            pt_q    <= 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  p_memreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == '0);

  p_busy_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid);

  p_seg_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_seg_bad |=> rsp_valid && rsp_fault == 2'b11);

  p_no_pt_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) && chk_fault != FLT_NONE |=> rsp_valid && !mem_req_valid);
endmodule

// File: tb/ptx_translator_bench.sv
module ptx_translator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] tbl = 24'h000100;
  logic [4:0]  lim = 5'd3;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [23:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int total = 0;
  int fails = 0;
  bit stall_en = 1'b0;
  bit [15:0] mem [int];
  int rd_q[$];
  int exp_q[$];

  always #4 clk = ~clk;

  ptx_translator u_ptx_translator (
    .clk(clk), .rst_n(rst_n), .seg_table_base(tbl), .seg_limit(lim),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  function automatic int rd(int a);
    return mem.exists(a) ? int'(mem[a]) : 0;
  endfunction

  // memory model: one-cycle read latency, optional request stalls
  logic mrdy = 1'b1;
  logic rsp_pend = 1'b0;
  logic [15:0] rsp_word = '0;
  always @(posedge clk) begin
    mrdy <= stall_en ? ~mrdy : 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      rsp_pend <= 1'b1;
      rsp_word <= 16'(rd(int'(mem_req_addr)));
      rd_q.push_back(int'(mem_req_addr));
    end else begin
      rsp_pend <= 1'b0;
    end
  end
  assign mem_req_ready = mrdy;
  assign mem_rsp_valid = rsp_pend;
  assign mem_rsp_data  = rsp_word;

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10: held request under stall
  logic prev_hold = 1'b0;
  logic [23:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n && stall_en && prev_hold) begin
      check("R10 req valid held", mem_req_valid, 1);
      check("R10 req addr held", mem_req_addr, prev_addr);
    end
    prev_hold <= mem_req_valid && !mem_req_ready;
    prev_addr <= mem_req_addr;
  end

  task automatic model(input logic [23:0] va, input bit wr,
                       output logic [1:0] f, output logic [23:0] pa, output int lat);
    int seg, pg, e, base, cnt, prot, pte;
    exp_q.delete();
    pa  = '0;
    seg = int'(va[23:20]);
    pg  = int'(va[19:12]);
    if (seg >= int'(lim)) begin f = 2'b11; lat = 0; return; end
    e = int'(tbl) + seg * 8;
    exp_q.push_back(e); exp_q.push_back(e + 2); exp_q.push_back(e + 4);
    base = ((rd(e + 2) & 'hFF) << 16) | rd(e);
    cnt  = rd(e + 2) >> 8;
    prot = rd(e + 4) & 3;
    lat  = 7;
    if (prot == 0 || prot == 3 || (prot == 1 && wr)) f = 2'b10;
    else if (pg >= cnt) f = 2'b01;
    else begin
      pte = (base + 2 * pg) & 'hFFFFFF;
      exp_q.push_back(pte);
      pa  = 24'(((rd(pte) & 'hFFF) << 12) | int'(va[11:0]));
      f   = 2'b00;
      lat = 9;
    end
  endtask

  task automatic txn(input logic [23:0] va, input bit wr, input int hold, input string tag);
    logic [1:0] ef; logic [23:0] ep; int el; int k;
    logic [23:0] pa0; logic [1:0] f0;
    model(va, wr, ef, ep, el);
    rd_q.delete();
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R8 busy after accept"}, req_ready, 0);
    k = 0;
    while (!rsp_valid && k < 60) begin @(negedge clk); k++; end
    if (!stall_en) check({tag, " R7 latency"}, k, el);
    check({tag, " fault"}, rsp_fault, ef);
    check({tag, " R12 paddr"}, rsp_paddr, ep);
    pa0 = rsp_paddr; f0 = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check({tag, " R9 valid held"}, rsp_valid, 1);
      check({tag, " R9 paddr held"}, rsp_paddr, pa0);
      check({tag, " R9 fault held"}, rsp_fault, f0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    check({tag, " R8 idle again"}, req_ready, 1);
    check({tag, " R2 R3 read count"}, rd_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rd_q.size(); i++)
      check({tag, " R2 R3 read addr"}, rd_q[i], exp_q[i]);
  endtask

  initial begin
    #(8 * 150000);
    total++; fails++;
    $display("FAIL R7 watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // segment 0: RO, 0x14 pages, PT at 0x002000
    mem[32'h100] = 16'h2000; mem[32'h102] = 16'h1400; mem[32'h104] = 16'h0001;
    // segment 1: no access, 0 pages
    mem[32'h108] = 16'h0000; mem[32'h10A] = 16'h0000; mem[32'h10C] = 16'h0000;
    // segment 2: RW, 0x0D pages, PT at 0x001000
    mem[32'h110] = 16'h1000; mem[32'h112] = 16'h0D00; mem[32'h114] = 16'h0002;
    // segment 3: reserved code, used once the limit is raised
    mem[32'h118] = 16'h3000; mem[32'h11A] = 16'h0800; mem[32'h11C] = 16'h0003;
    mem[32'h2004] = 16'hA003;
    mem[32'h2026] = 16'h7ABC;
    mem[32'h1018] = 16'h0555;

    repeat (3) @(negedge clk);
    check("R11 req_ready in reset", req_ready, 1);
    check("R11 rsp_valid in reset", rsp_valid, 0);
    check("R11 mem_req_valid in reset", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 req_ready after reset", req_ready, 1);
    check("R11 rsp_valid after reset", rsp_valid, 0);

    txn(24'h002070, 1'b0, 0, "R1 R3 basic");
    check("R1 frame join", rsp_paddr, 24'h003070);
    txn(24'h013FFF, 1'b0, 0, "R1 last page");
    txn(24'h014000, 1'b0, 0, "R4 page equals count");
    txn(24'h002070, 1'b1, 2, "R5 write to read-only");
    txn(24'h1000AA, 1'b0, 0, "R5 no access read");
    txn(24'h100000, 1'b1, 0, "R5 precedence over bounds");
    txn(24'h210014, 1'b1, 0, "R4 page beyond count");
    txn(24'h20C123, 1'b1, 0, "R1 write in RW");
    txn(24'h300000, 1'b0, 0, "R6 segment at limit");
    txn(24'hF00000, 1'b1, 3, "R6 top segment");
    @(negedge clk); lim = 5'd16;
    txn(24'h300000, 1'b0, 0, "R5 reserved code");
    stall_en = 1'b1;
    txn(24'h20C123, 1'b0, 4, "R9 R10 stalled");
    txn(24'h013FFF, 1'b0, 1, "R10 stalled read");
    stall_en = 1'b0;
    txn(24'h002070, 1'b0, 0, "R7 after stall");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule